// File: doc/BRIEF.md
# Serial four-channel DAC command front end

This block is the digital control side of a four-channel, 8-bit digital-to-analog converter. A host writes to it over a three-wire serial link: a serial clock, a data line and an enable strobe. The block samples all three lines, plus a hardware activate input, with a fast system clock. It finds the serial clock edges itself, assembles 12-bit words and decodes them. A word either loads a code for one channel or rewrites the control settings: buffering mode, per-channel gain range, per-channel shutdown inhibit and a software activate bit.

Two update modes are supported. In double-buffered mode, writes are only staged, and the whole staged set moves to the outputs when enable falls. Several devices can then share one clock and data line, each with its own enable. In single-buffered mode the outputs follow each completed word, so enable may be tied high. The block switches from double to single buffering once and never switches back until reset. A run of twelve zero bits puts a drifted receiver back in step with the sender.

Each channel presents its 8-bit code, a gain flag (x2 when set) and an active flag. The active flag is formed from the channel's inhibit bit, the latched software activate bit and the synchronized hardware activate input. A synchronous reset takes the place of a power-on reset.

Top module: `qdac_front`

## Requirements
- R1: After reset, all codes are 0, all gain flags are 1, all active flags are 0, and the block is in double-buffered mode.
- R2: A word is 12 bits, shifted MSB first, one bit per falling edge of the serial clock while enable is high. If bit 11 is 0, the word is a data word: bits 10:9 give the channel (00 = A, 01 = B, 10 = C, 11 = D), bit 8 is ignored and bits 7:0 give the code. If bit 11 is 1, the word is a control word: bit 10 = single-buffer request, bits 9:6 = gain flags (bit 6 = A … bit 9 = D), bits 5:2 = inhibit bits (bit 2 = A … bit 5 = D), bit 1 = software activate, bit 0 ignored. Channel A sits in code_o[7:0] and in bit 0 of each flag port.
- R3: Serial clock edges while enable is low have no effect. A rising edge of enable discards a partly shifted word, so the next bit starts a new word.
- R4: In double-buffered mode, codes, gain flags and inhibit bits reach the outputs only on a falling edge of enable. A second write to the same channel before that edge replaces the first.
- R5: When a control word with the single-buffer bit set completes, the outputs take all staged values at once, including that word's own fields, without an enable edge. From then on, each completed word updates the outputs directly.
- R6: Once single-buffered mode is entered, a control word with bit 10 cleared does not leave it. Only reset returns the block to double-buffered mode.
- R7: The software activate bit reaches the active flags only on a falling edge of enable, in either mode.
- R8: Channel x is active when its inhibit bit is 1, or when both the latched software activate bit and the hardware activate input are 1. Otherwise it is shut down.
- R9: Twelve consecutive zero bits, counted across word boundaries, reset the bit position, so the next bit starts a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_en_i | input | 1 | Serial enable; its falling edge commits staged values |
| hw_act_i | input | 1 | Hardware activate input |
| code_o | output | 32 | Live channel codes, channel A in the low byte |
| gain2_o | output | 4 | Live gain flags, 1 = x2 range |
| active_o | output | 4 | Per-channel active flags, 0 = shut down |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit codes and two synchronizer stages. This configuration is small enough for the bench to write every one of the 256 code values across the four channels, and to step through all 64 combinations of inhibit pattern, software activate and hardware activate. Directed sequences then cover the commit on the enable edge, overwriting a staged value, discarding a partial word, recovering alignment with a zero run after junk bits, and the one-way mode switch, both across later words and across a reset.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   localparam int QD_CHANS  = 4;
   localparam int QD_CODE_W = 8;
   localparam int QD_SYNC   = 2;

   typedef enum logic {
      WK_DATA = 1'b0,
      WK_CTRL = 1'b1
   } word_kind_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qdac_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qdac_deser.sv
module qdac_deser #(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk_s_i,
   input  logic              sdat_s_i,
   input  logic              en_s_i,
   output logic              word_vld_o,
   output logic [WORD_W-1:0] word_o,
   output logic              en_fall_o
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   generate
      if (WORD_W < 4) begin : g_bad_word
         $error("qdac_deser: WORD_W too small");
      end
   endgenerate

   logic              sclk_d_q, en_d_q;
   logic [WORD_W-2:0] sh_q;
   logic [CNT_W-1:0]  cnt_q, zrun_q;
   logic              vld_q, en_fall_q;
   logic [WORD_W-1:0] word_q;

   logic sclk_fall, en_rise, shift;
   assign sclk_fall = sclk_d_q & ~sclk_s_i;
   assign en_rise   = ~en_d_q & en_s_i;
   assign shift     = en_s_i & sclk_fall;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_d_q  <= 1'b0;
         en_d_q    <= 1'b0;
         sh_q      <= '0;
         cnt_q     <= '0;
         zrun_q    <= '0;
         vld_q     <= 1'b0;
         en_fall_q <= 1'b0;
         word_q    <= '0;
      end else begin
         sclk_d_q  <= sclk_s_i;
         en_d_q    <= en_s_i;
         vld_q     <= 1'b0;
         en_fall_q <= en_d_q & ~en_s_i;
         if (en_rise) begin
            cnt_q  <= '0;
            zrun_q <= '0;
         end else if (shift) begin
            sh_q <= {sh_q[WORD_W-3:0], sdat_s_i};
            if (cnt_q == LAST) begin
               cnt_q  <= '0;
               vld_q  <= 1'b1;
               word_q <= {sh_q, sdat_s_i};
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            if (sdat_s_i) begin
               zrun_q <= '0;
            end else if (zrun_q == LAST) begin
               zrun_q <= '0;
               cnt_q  <= '0;
            end else begin
               zrun_q <= zrun_q + 1'b1;
            end
         end
      end
   end

   assign word_vld_o = vld_q;
   assign word_o     = word_q;
   assign en_fall_o  = en_fall_q;

   // R3
   bitcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en_s_i |=> $stable(cnt_q));

   // R2
   word_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      vld_q |=> !vld_q);

   // R9
   zrun_reset_chk: assert property (@(posedge clk) disable iff (rst)
      (shift && !en_rise && !sdat_s_i && zrun_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
   import qdac_pkg::*;
#(
   parameter int CHANS  = 4,
   parameter int CODE_W = 8,
   parameter int ADDR_W = 2,
   parameter int WORD_W = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    word_vld_i,
   input  logic [WORD_W-1:0]       word_i,
   input  logic                    en_fall_i,
   output logic [CHANS*CODE_W-1:0] code_o,
   output logic [CHANS-1:0]        gain_o,
   output logic [CHANS-1:0]        inh_o,
   output logic                    act_o
);
   localparam int MODE_B   = WORD_W - 2;
   localparam int RNG_LSB  = MODE_B - CHANS;
   localparam int INH_LSB  = RNG_LSB - CHANS;
   localparam int ACT_B    = INH_LSB - 1;
   localparam int ADDR_LSB = WORD_W - 1 - ADDR_W;

   generate
      if ((1 << ADDR_W) != CHANS) begin : g_bad_chans
         $error("qdac_regs: CHANS must equal 2**ADDR_W");
      end
      if (ACT_B < 0) begin : g_bad_ctrl
         $error("qdac_regs: control fields do not fit in the word");
      end
      if (ADDR_LSB < CODE_W) begin : g_bad_data
         $error("qdac_regs: data fields do not fit in the word");
      end
   endgenerate

   logic [CODE_W-1:0] stg_code [CHANS];
   logic [CODE_W-1:0] nx_code  [CHANS];
   logic [CODE_W-1:0] live_code[CHANS];
   logic [CHANS-1:0]  stg_rng, stg_inh, nx_rng, nx_inh, live_rng, live_inh;
   logic              stg_act, nx_act, live_act, mode_q, nx_mode, pub;

   logic unused_word_bits;
   assign unused_word_bits = ^word_i;

   always_comb begin
      nx_code = stg_code;
      nx_rng  = stg_rng;
      nx_inh  = stg_inh;
      nx_act  = stg_act;
      nx_mode = mode_q;
      if (word_vld_i) begin
         if (word_kind_e'(word_i[WORD_W-1]) == WK_CTRL) begin
            nx_mode = mode_q | word_i[MODE_B];
            nx_rng  = word_i[RNG_LSB +: CHANS];
            nx_inh  = word_i[INH_LSB +: CHANS];
            nx_act  = word_i[ACT_B];
         end else begin
            nx_code[word_i[ADDR_LSB +: ADDR_W]] = word_i[CODE_W-1:0];
         end
      end
   end

   assign pub = en_fall_i | (word_vld_i & nx_mode);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < CHANS; i++) begin
            stg_code[i]  <= '0;
            live_code[i] <= '0;
         end
         stg_rng  <= '1;
         live_rng <= '1;
         stg_inh  <= '0;
         live_inh <= '0;
         stg_act  <= 1'b0;
         live_act <= 1'b0;
         mode_q   <= 1'b0;
      end else begin
         stg_code <= nx_code;
         stg_rng  <= nx_rng;
         stg_inh  <= nx_inh;
         stg_act  <= nx_act;
         mode_q   <= nx_mode;
         if (pub) begin
            live_code <= nx_code;
            live_rng  <= nx_rng;
            live_inh  <= nx_inh;
         end
         if (en_fall_i) live_act <= nx_act;
      end
   end

   generate
      for (genvar c = 0; c < CHANS; c++) begin : g_pack
         assign code_o[c*CODE_W +: CODE_W] = live_code[c];
      end
   endgenerate

   assign gain_o = live_rng;
   assign inh_o  = live_inh;
   assign act_o  = live_act;

   // R6
   mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      mode_q |=> mode_q);

   // R4
   code_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!en_fall_i && !word_vld_i) |=> $stable(code_o));

   // R7
   act_latch_chk: assert property (@(posedge clk) disable iff (rst)
      !en_fall_i |=> $stable(live_act));

   // R4
   gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mode_q && !en_fall_i && word_vld_i && !word_i[WORD_W-1]) |=> $stable(gain_o));
endmodule

// File: rtl/qdac_front.sv
module qdac_front
   import qdac_pkg::*;
#(
   parameter int CHANS       = QD_CHANS,
   parameter int CODE_W      = QD_CODE_W,
   parameter int SYNC_STAGES = QD_SYNC
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ser_clk_i,
   input  logic                    ser_dat_i,
   input  logic                    ser_en_i,
   input  logic                    hw_act_i,
   output logic [CHANS*CODE_W-1:0] code_o,
   output logic [CHANS-1:0]        gain2_o,
   output logic [CHANS-1:0]        active_o
);
   localparam int ADDR_W = (CHANS > 1) ? $clog2(CHANS) : 1;
   localparam int WORD_W = 2 + ADDR_W + CODE_W;

   logic [3:0] raw_in, syn;
   assign raw_in = {hw_act_i, ser_en_i, ser_dat_i, ser_clk_i};

   qdac_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (raw_in),
      .q_o (syn)
   );

   logic              wvld, en_fall;
   logic [WORD_W-1:0] word;

   qdac_deser #(.WORD_W(WORD_W)) u_deser (
      .clk        (clk),
      .rst        (rst),
      .sclk_s_i   (syn[0]),
      .sdat_s_i   (syn[1]),
      .en_s_i     (syn[2]),
      .word_vld_o (wvld),
      .word_o     (word),
      .en_fall_o  (en_fall)
   );

   logic [CHANS-1:0] inh;
   logic             act;

   qdac_regs #(.CHANS(CHANS), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .word_vld_i (wvld),
      .word_i     (word),
      .en_fall_i  (en_fall),
      .code_o     (code_o),
      .gain_o     (gain2_o),
      .inh_o      (inh),
      .act_o      (act)
   );

   generate
      for (genvar c = 0; c < CHANS; c++) begin : g_act
         assign active_o[c] = inh[c] | (act & syn[3]);
      end
   endgenerate

   // R8
   shutdown_chk: assert property (@(posedge clk) disable iff (rst)
      (!act) |-> (active_o == inh));
endmodule

// File: tb/sim_qdac_front.sv
module sim_qdac_front;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0, hw = 1'b0;
   logic [31:0] code_o;
   logic [3:0]  gain2_o, active_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [7:0] exp_code [4];
   logic [3:0] exp_rng, exp_inh;
   logic       exp_act;

   always #10 clk = ~clk;

   qdac_front u0 (
      .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
      .ser_en_i(ser_en), .hw_act_i(hw),
      .code_o(code_o), .gain2_o(gain2_o), .active_o(active_o)
   );

   task automatic idle(int n); repeat (n) @(negedge clk); endtask
   task automatic sbit(logic b); ser_dat = b; ser_clk = 1'b1; idle(4); ser_clk = 1'b0; idle(4); endtask
   task automatic sword(logic [11:0] w); for (int i = 11; i >= 0; i--) sbit(w[i]); endtask
   task automatic en_up; ser_en = 1'b1; idle(4); endtask
   task automatic en_dn; ser_en = 1'b0; idle(6); endtask

   function automatic logic [11:0] dword(int ch, logic [7:0] c);
      logic [1:0] a = ch[1:0];
      return {1'b0, a, 1'b0, c};
   endfunction
   function automatic logic [11:0] cword(logic m, logic [3:0] rg, logic [3:0] ih, logic ac);
      return {1'b1, m, rg, ih, ac, 1'b0};
   endfunction

   function automatic logic [3:0] exp_live();
      return exp_inh | {4{exp_act & hw}};
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] want);
      n_chk++;
      if (got !== want) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, got, want);
      end
   endtask

   task automatic chk_all(string req);
      chk(req, code_o, {exp_code[3], exp_code[2], exp_code[1], exp_code[0]});
      chk(req, {28'd0, gain2_o}, {28'd0, exp_rng});
      chk(req, {28'd0, active_o}, {28'd0, exp_live()});
   endtask

   task automatic model_reset;
      for (int i = 0; i < 4; i++) exp_code[i] = 8'h00;
      exp_rng = 4'hF; exp_inh = 4'h0; exp_act = 1'b0;
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      model_reset();
      idle(5); rst = 1'b0; idle(4);
      chk_all("R1 reset state");

      // R4 staging and commit on enable fall
      en_up(); sword(dword(0, 8'h5A));
      chk_all("R4 staged not visible");
      en_dn(); exp_code[0] = 8'h5A;
      chk_all("R4 commit on enable fall");
      en_up(); sword(dword(1, 8'h11)); sword(dword(1, 8'h22)); en_dn();
      exp_code[1] = 8'h22;
      chk_all("R4 overwrite same channel");

      // R3 enable low ignores clocks; partial word discarded
      sword(dword(2, 8'hFF)); en_up(); en_dn();
      chk_all("R3 clocks with enable low");
      en_up(); sbit(1); sbit(1); sbit(0); sbit(1); sbit(1);
      ser_en = 1'b0; idle(4);
      en_up(); sword(dword(3, 8'h3C)); en_dn();
      exp_code[3] = 8'h3C;
      chk_all("R3 partial word discarded");

      // R8 / R2 sweep of inhibit, activate and hardware activate
      for (int ih = 0; ih < 16; ih++) begin
         for (int a = 0; a < 2; a++) begin
            for (int h = 0; h < 2; h++) begin
               hw = h[0];
               en_up(); sword(cword(1'b0, ~ih[3:0], ih[3:0], a[0])); en_dn(); idle(2);
               exp_rng = ~ih[3:0]; exp_inh = ih[3:0]; exp_act = a[0];
               chk_all("R8 R2 control sweep");
            end
         end
      end

      // R7 activate bit waits for enable fall
      hw = 1'b1;
      en_up(); sword(cword(1'b0, 4'hF, 4'h0, 1'b0)); en_dn();
      exp_rng = 4'hF; exp_inh = 4'h0; exp_act = 1'b0;
      chk_all("R7 activate cleared");
      en_up(); sword(cword(1'b0, 4'hF, 4'h0, 1'b1));
      chk("R7 activate before enable fall", {28'd0, active_o}, 32'd0);
      en_dn(); exp_act = 1'b1;
      chk_all("R7 activate after enable fall");
      hw = 1'b0; idle(5);
      chk_all("R8 hardware activate low");

      // R2 code sweep over all values
      for (int i = 0; i < 256; i++) begin
         en_up(); sword(dword(i % 4, i[7:0])); en_dn();
         exp_code[i % 4] = i[7:0];
         chk("R2 code sweep", code_o, {exp_code[3], exp_code[2], exp_code[1], exp_code[0]});
      end

      // R9 resync after junk bits with twelve zeros
      en_up();
      sbit(0); sbit(1); sbit(1); sbit(0); sbit(1);
      for (int z = 0; z < 12; z++) sbit(0);
      sword(dword(1, 8'h77)); en_dn();
      exp_code[3] = 8'h80; exp_code[1] = 8'h77;
      chk_all("R9 zero run resync");

      // R5 / R6 single-buffered mode, enable held high
      en_up();
      sword(dword(0, 8'h33));
      chk_all("R5 staged before mode switch");
      sword(cword(1'b1, 4'b0101, 4'b0011, 1'b0));
      exp_code[0] = 8'h33; exp_rng = 4'b0101; exp_inh = 4'b0011;
      chk_all("R5 mode switch publishes");
      sword(dword(2, 8'h99)); exp_code[2] = 8'h99;
      chk_all("R5 direct update");
      sword(cword(1'b0, 4'b1010, 4'b1100, 1'b0));
      exp_rng = 4'b1010; exp_inh = 4'b1100;
      chk_all("R6 mode bit clear ignored");
      sword(dword(3, 8'h12)); exp_code[3] = 8'h12;
      chk_all("R6 still single buffered");
      hw = 1'b1;
      sword(cword(1'b0, 4'hF, 4'h0, 1'b0));
      exp_rng = 4'hF; exp_inh = 4'h0;
      chk_all("R7 single mode activate held");
      en_dn(); exp_act = 1'b0;
      chk_all("R7 single mode activate latched");
      en_up(); sword(cword(1'b0, 4'hF, 4'h0, 1'b1));
      chk_all("R7 single mode before fall");
      en_dn(); exp_act = 1'b1;
      chk_all("R7 single mode after fall");

      // R1 / R6 reset returns double-buffered mode
      rst = 1'b1; idle(3); rst = 1'b0; idle(4);
      model_reset();
      chk_all("R1 second reset");
      en_up(); sword(dword(0, 8'h44));
      chk_all("R6 double buffered after reset");
      en_dn(); exp_code[0] = 8'h44;
      chk_all("R6 commit after reset");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule